// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block performs the state changes a register-windowed processor makes when it enters a trap handler and when it returns from one. It takes three kinds of request: a hardware trap that carries an 8-bit trap type, a software trap instruction that carries two operands, and a return-from-trap instruction that carries two operands. From these it updates the processor-state bits (trap enable, supervisor, previous supervisor, current window pointer) and the trap base register. It also issues a registered redirect of the fetch address and drives a write port that saves the interrupted PC and next PC into two local registers.

The handler address is the upper field of the trap base joined with the trap type placed at bits 11:4, so each handler slot is 16 bytes. A software trap that arrives while traps are disabled does not vector. Instead it places the block in a sticky error mode, which only reset clears. Instruction fetch, the register file and memory are outside the block; they take the redirect and save ports.

Top module: `trap_seq_ctrl`

## Requirements
- R1: While reset is held and directly after it, trap enable is 1, supervisor is 1, previous supervisor is 0, the window pointer is 0, the trap base is 0, error mode is 0, and redirect, save write and annul clear are all 0.
- R2: On trap entry the handler address is {trap_base[31:12], tt, 4'b0000}. This value becomes the new trap base, so bits 11:4 hold the trap type. redirect_pc equals the handler address and redirect_npc equals the handler address + 4.
- R3: On trap entry, trap enable goes to 0, previous supervisor takes the old supervisor bit, supervisor goes to 1, and the window pointer becomes (cwp - 1) mod NWIN. A hardware request vectors whatever the state of trap enable.
- R4: On trap entry, save_we pulses for one cycle with save_l1 equal to cur_pc and save_l2 equal to cur_npc, as sampled at the request. annul_clr pulses in the same cycle.
- R5: A software trap uses trap type 128 + ((sw_opa + sw_opb) mod 128).
- R6: A software trap that arrives while trap enable is 0 sets error mode. It produces no redirect, no save and no change of state or trap base.
- R7: On return, supervisor takes previous supervisor, trap enable goes to 1, and the window pointer becomes (cwp + 1) mod NWIN. redirect_pc is ret_opa + ret_opb, redirect_npc is that value + 4, and neither save_we nor annul_clr is raised.
- R8: A base write replaces only trap_base[31:12] with base_wdata, leaving bits 11:0 unchanged. The write is discarded in any cycle that has a hardware or software trap request.
- R9: Requests are ranked hardware, then software, then return. Only the highest-ranked request present acts; the others are dropped.
- R10: Every output change appears on the clock edge that samples the request. redirect is high for exactly the cycles that follow an accepted request.
- R11: Error mode stays set until reset. While it is set, all trap, return and base-write requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 1 | Hardware trap request |
| hw_tt | input | 8 | Hardware trap type |
| sw_req | input | 1 | Software trap instruction |
| sw_opa | input | 7 | Low bits of first trap operand |
| sw_opb | input | 7 | Low bits of second trap operand |
| ret_req | input | 1 | Return-from-trap instruction |
| ret_opa | input | 32 | First return operand |
| ret_opb | input | 32 | Second return operand |
| base_we | input | 1 | Trap base upper-field write |
| base_wdata | input | 20 | New value for trap_base[31:12] |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_npc | input | 32 | Next PC of the interrupted instruction |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | New PC |
| redirect_npc | output | 32 | New next PC |
| save_we | output | 1 | Local register save strobe |
| save_l1 | output | 32 | Value for local register 1 (old PC) |
| save_l2 | output | 32 | Value for local register 2 (old next PC) |
| annul_clr | output | 1 | Clear pending annul |
| st_et | output | 1 | Trap enable bit |
| st_s | output | 1 | Supervisor bit |
| st_ps | output | 1 | Previous supervisor bit |
| st_cwp | output | 3 | Current window pointer |
| trap_base | output | 32 | Trap base register |
| err_mode | output | 1 | Sticky error mode |

## Verification
The case hardest to reach from the ports is the window pointer wrapping from 0 to NWIN-1 while the previous-supervisor bit holds a value that differs from its reset value. The stimulus first issues a return straight after reset, which clears the supervisor bit. It then nests more hardware traps than there are windows, which walks the pointer through the wrap, and unwinds them with returns. Error mode needs trap enable at 0 before a software trap arrives, so the sequence enters a trap first and then issues the software trap. It follows with every kind of request to confirm that none of them has an effect.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int XLEN       = 32;
  localparam int TT_W       = 8;
  localparam int VEC_LSB    = 4;
  localparam int INSN_BYTES = 4;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_ENTER,
    ACT_FAULT,
    ACT_RETURN
  } act_e;
endpackage

// File: rtl/trap_req_arb.sv
module trap_req_arb
  import trap_seq_pkg::*;
#(
  parameter int TW = TT_W
) (
  input  logic          hw_req,
  input  logic [TW-1:0] hw_tt,
  input  logic          sw_req,
  input  logic [TW-2:0] sw_opa,
  input  logic [TW-2:0] sw_opb,
  input  logic          ret_req,
  input  logic          et,
  input  logic          halted,
  output act_e          act,
  output logic [TW-1:0] tt
);
  logic [TW-2:0] sw_low;

  assign sw_low = sw_opa + sw_opb;

  // hardware type wins; software types sit in the upper half of the space
  always_comb begin
    tt = hw_req ? hw_tt : {1'b1, sw_low};
  end

  always_comb begin
    if (halted)       act = ACT_IDLE;
    else if (hw_req)  act = ACT_ENTER;
    else if (sw_req)  act = et ? ACT_ENTER : ACT_FAULT;
    else if (ret_req) act = ACT_RETURN;
    else              act = ACT_IDLE;
  end
endmodule

// File: rtl/trap_win_step.sv
module trap_win_step #(
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input  logic [CW-1:0] cwp,
  output logic [CW-1:0] cwp_dec,
  output logic [CW-1:0] cwp_inc
);
  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      // natural wrap of the counter width
      assign cwp_dec = cwp - CW'(1);
      assign cwp_inc = cwp + CW'(1);
    end else begin : g_mod
      assign cwp_dec = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
      assign cwp_inc = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
    end
  endgenerate
endmodule

// File: rtl/trap_vec_form.sv
module trap_vec_form
  import trap_seq_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int TW = TT_W,
  localparam int BL = TW + VEC_LSB
) (
  input  logic [XW-BL-1:0] base_hi,
  input  logic [TW-1:0]    tt,
  output logic [XW-1:0]    vec,
  output logic [XW-1:0]    vec_nxt
);
  assign vec     = {base_hi, tt, {VEC_LSB{1'b0}}};
  assign vec_nxt = vec + XW'(INSN_BYTES);
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XW   = XLEN,
  parameter int TW   = TT_W,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int BL  = TW + VEC_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_req,
  input  logic [TW-1:0]    hw_tt,
  input  logic             sw_req,
  input  logic [TW-2:0]    sw_opa,
  input  logic [TW-2:0]    sw_opb,
  input  logic             ret_req,
  input  logic [XW-1:0]    ret_opa,
  input  logic [XW-1:0]    ret_opb,
  input  logic             base_we,
  input  logic [XW-BL-1:0] base_wdata,
  input  logic [XW-1:0]    cur_pc,
  input  logic [XW-1:0]    cur_npc,
  output logic             redirect,
  output logic [XW-1:0]    redirect_pc,
  output logic [XW-1:0]    redirect_npc,
  output logic             save_we,
  output logic [XW-1:0]    save_l1,
  output logic [XW-1:0]    save_l2,
  output logic             annul_clr,
  output logic             st_et,
  output logic             st_s,
  output logic             st_ps,
  output logic [CW-1:0]    st_cwp,
  output logic [XW-1:0]    trap_base,
  output logic             err_mode
);
  localparam logic [XW-1:0] STEP = XW'(INSN_BYTES);

  act_e          act;
  logic [TW-1:0] tt;
  logic [XW-1:0] vec, vec_nxt, ret_tgt;
  logic [CW-1:0] cwp_dec, cwp_inc;
  logic          base_ok;

  trap_req_arb #(.TW(TW)) u_arb (
    .hw_req (hw_req),
    .hw_tt  (hw_tt),
    .sw_req (sw_req),
    .sw_opa (sw_opa),
    .sw_opb (sw_opb),
    .ret_req(ret_req),
    .et     (st_et),
    .halted (err_mode),
    .act    (act),
    .tt     (tt)
  );

  trap_win_step #(.NWIN(NWIN), .CW(CW)) u_win (
    .cwp    (st_cwp),
    .cwp_dec(cwp_dec),
    .cwp_inc(cwp_inc)
  );

  trap_vec_form #(.XW(XW), .TW(TW)) u_vec (
    .base_hi(trap_base[XW-1:BL]),
    .tt     (tt),
    .vec    (vec),
    .vec_nxt(vec_nxt)
  );

  assign ret_tgt = ret_opa + ret_opb;
  // a trap in the same cycle owns the base register
  assign base_ok = base_we && !err_mode && !hw_req && !sw_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect     <= 1'b0;
      redirect_pc  <= '0;
      redirect_npc <= '0;
      save_we      <= 1'b0;
      save_l1      <= '0;
      save_l2      <= '0;
      annul_clr    <= 1'b0;
      st_et        <= 1'b1;
      st_s         <= 1'b1;
      st_ps        <= 1'b0;
      st_cwp       <= '0;
      trap_base    <= '0;
      err_mode     <= 1'b0;
    end else begin
      redirect  <= 1'b0;
      save_we   <= 1'b0;
      annul_clr <= 1'b0;
      unique case (act)
        ACT_ENTER: begin
          redirect     <= 1'b1;
          redirect_pc  <= vec;
          redirect_npc <= vec_nxt;
          save_we      <= 1'b1;
          save_l1      <= cur_pc;
          save_l2      <= cur_npc;
          annul_clr    <= 1'b1;
          st_et        <= 1'b0;
          st_ps        <= st_s;
          st_s         <= 1'b1;
          st_cwp       <= cwp_dec;
          trap_base    <= vec;
        end
        ACT_FAULT: err_mode <= 1'b1;
        ACT_RETURN: begin
          redirect     <= 1'b1;
          redirect_pc  <= ret_tgt;
          redirect_npc <= ret_tgt + STEP;
          st_s         <= st_ps;
          st_et        <= 1'b1;
          st_cwp       <= cwp_inc;
        end
        default: ;
      endcase
      if (base_ok) trap_base[XW-1:BL] <= base_wdata;
    end
  end

  p_enter_state_r3: assert property (@(posedge clk) disable iff (rst)
    annul_clr |-> (!st_et && st_s && st_ps == $past(st_s) &&
                   st_cwp == (($past(st_cwp) == '0) ? CW'(NWIN - 1)
                                                     : CW'($past(st_cwp) - CW'(1)))));

  p_enter_vec_r2: assert property (@(posedge clk) disable iff (rst)
    annul_clr |-> (redirect && save_we && redirect_pc == trap_base &&
                   redirect_npc == redirect_pc + STEP &&
                   trap_base[VEC_LSB-1:0] == '0));

  p_return_state_r7: assert property (@(posedge clk) disable iff (rst)
    (redirect && !annul_clr) |-> (st_et && st_s == $past(st_ps) && !save_we));

  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_mode) |-> (!redirect && $stable(st_cwp) && $stable(trap_base)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_mode |=> err_mode);

  p_redirect_cause_r10: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(hw_req || sw_req || ret_req));

  p_base_low_r8: assert property (@(posedge clk) disable iff (rst)
    !annul_clr |-> (trap_base[BL-1:0] == $past(trap_base[BL-1:0])));
endmodule

// File: tb/trap_seq_ctrl_tb.sv
module trap_seq_ctrl_tb;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        hw_req = 0, sw_req = 0, ret_req = 0, base_we = 0;
  logic [7:0]  hw_tt = '0;
  logic [6:0]  sw_opa = '0, sw_opb = '0;
  logic [31:0] ret_opa = '0, ret_opb = '0, cur_pc = '0, cur_npc = '0;
  logic [19:0] base_wdata = '0;
  logic        redirect, save_we, annul_clr, st_et, st_s, st_ps, err_mode;
  logic [31:0] redirect_pc, redirect_npc, save_l1, save_l2, trap_base;
  logic [2:0]  st_cwp;

  int nchk = 0, nerr = 0;

  logic       m_et, m_s, m_ps, m_err;
  logic [2:0] m_cwp;
  logic [31:0] m_base;

  trap_seq_ctrl #(.NWIN(NW)) u_dut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .hw_tt(hw_tt),
    .sw_req(sw_req), .sw_opa(sw_opa), .sw_opb(sw_opb),
    .ret_req(ret_req), .ret_opa(ret_opa), .ret_opb(ret_opb),
    .base_we(base_we), .base_wdata(base_wdata),
    .cur_pc(cur_pc), .cur_npc(cur_npc),
    .redirect(redirect), .redirect_pc(redirect_pc), .redirect_npc(redirect_npc),
    .save_we(save_we), .save_l1(save_l1), .save_l2(save_l2),
    .annul_clr(annul_clr), .st_et(st_et), .st_s(st_s), .st_ps(st_ps),
    .st_cwp(st_cwp), .trap_base(trap_base), .err_mode(err_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R3/R7 et"},  32'(st_et),  32'(m_et));
    chk({tag, " R3/R7 s"},   32'(st_s),   32'(m_s));
    chk({tag, " R3/R7 ps"},  32'(st_ps),  32'(m_ps));
    chk({tag, " R3/R7 cwp"}, 32'(st_cwp), 32'(m_cwp));
    chk({tag, " R2/R8 base"}, trap_base, m_base);
    chk({tag, " R6/R11 err"}, 32'(err_mode), 32'(m_err));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_et = 1; m_s = 1; m_ps = 0; m_cwp = '0; m_base = '0; m_err = 0;
    chk("R1 redirect", 32'(redirect), 0);
    chk("R1 save_we", 32'(save_we), 0);
    chk("R1 annul_clr", 32'(annul_clr), 0);
    check_state("R1");
    rst = 1'b0;
  endtask

  task automatic apply(input string tag, input logic h, input logic [7:0] htt,
                       input logic sw, input logic [6:0] sa, input logic [6:0] sb,
                       input logic rt, input logic [31:0] ra, input logic [31:0] rb,
                       input logic bw, input logic [19:0] bd,
                       input logic [31:0] pc, input logic [31:0] npc);
    logic        e_red, e_sav;
    logic [31:0] e_pc, e_npc, vec;
    logic [7:0]  t;
    e_red = 0; e_sav = 0; e_pc = '0; e_npc = '0;
    hw_req = h; hw_tt = htt; sw_req = sw; sw_opa = sa; sw_opb = sb;
    ret_req = rt; ret_opa = ra; ret_opb = rb; base_we = bw; base_wdata = bd;
    cur_pc = pc; cur_npc = npc;
    if (!m_err) begin
      if (h || (sw && m_et)) begin
        t = h ? htt : (8'd128 + 8'((32'(sa) + 32'(sb)) % 128));
        vec = (m_base & 32'hFFFF_F000) | (32'(t) << 4);
        m_base = vec; m_ps = m_s; m_s = 1; m_et = 0;
        m_cwp = (m_cwp == 0) ? 3'(NW - 1) : m_cwp - 3'd1;
        e_red = 1; e_sav = 1; e_pc = vec; e_npc = vec + 32'd4;
      end else if (sw) begin
        m_err = 1;
      end else if (rt) begin
        m_s = m_ps; m_et = 1;
        m_cwp = (m_cwp == 3'(NW - 1)) ? 3'd0 : m_cwp + 3'd1;
        e_red = 1; e_pc = ra + rb; e_npc = ra + rb + 32'd4;
      end
      if (bw && !h && !sw) m_base = {bd, m_base[11:0]};
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R10 redirect"}, 32'(redirect), 32'(e_red));
    if (e_red) begin
      chk({tag, " R2/R7 redirect_pc"}, redirect_pc, e_pc);
      chk({tag, " R2/R7 redirect_npc"}, redirect_npc, e_npc);
    end
    chk({tag, " R4 save_we"}, 32'(save_we), 32'(e_sav));
    chk({tag, " R4 annul_clr"}, 32'(annul_clr), 32'(e_sav));
    if (e_sav) begin
      chk({tag, " R4 save_l1"}, save_l1, pc);
      chk({tag, " R4 save_l2"}, save_l2, npc);
    end
    check_state(tag);
    hw_req = 0; sw_req = 0; ret_req = 0; base_we = 0;
  endtask

  task automatic idle(input string tag);
    apply(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic hw(input string tag, input logic [7:0] t, input logic [31:0] pc);
    apply(tag, 1, t, 0, 0, 0, 0, 0, 0, 0, 0, pc, pc + 32'd4);
  endtask

  task automatic ret(input string tag, input logic [31:0] a, input logic [31:0] b);
    apply(tag, 0, 0, 0, 0, 0, 1, a, b, 0, 0, 0, 0);
  endtask

  initial begin
    #600000;
    nerr++; nchk++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();
    // R8: base write sets only the upper field
    apply("R8 wr", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'hABCDE, 0, 0);
    // R7: return straight after reset clears supervisor
    ret("R7 first", 32'h1000, 32'h20);
    // R2/R3/R4: sweep every hardware trap type
    for (int t = 0; t < 256; t++) begin
      hw("R2 sweep", 8'(t), 32'h4000_0000 + 32'(t) * 8);
      idle("R10 idle");
      ret("R7 sweep", 32'(t) << 8, 32'(t));
    end
    // R3: nest past the window count to wrap the pointer
    for (int i = 0; i < 10; i++) hw("R3 nest", 8'(i + 1), 32'h8000 + 32'(i) * 4);
    for (int i = 0; i < 10; i++) ret("R7 unwind", 32'(i) * 16, 32'h4);
    // R8: base write keeps the type field; dropped with a trap
    hw("R8 pre", 8'h3C, 32'h100);
    apply("R8 keep", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h55555, 0, 0);
    apply("R8 clash", 1, 8'h11, 0, 0, 0, 0, 0, 0, 1, 20'hFFFFF, 32'h200, 32'h204);
    apply("R8 withret", 0, 0, 0, 0, 0, 1, 32'h300, 32'h4, 1, 20'h0F0F0, 0, 0);
    // R5: exhaustive software operand sweep
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        if (!m_et) ret("R7 pre", 32'h10, 32'h0);
        apply("R5 sw", 0, 0, 1, 7'(a), 7'(b), 0, 0, 0, 0, 0, 32'(a) << 12, 32'(b));
      end
    end
    // R9: priority
    ret("R9 pre", 32'h40, 32'h0);
    apply("R9 all", 1, 8'h05, 1, 7'd1, 7'd2, 1, 32'h50, 32'h0, 0, 0, 32'h600, 32'h604);
    ret("R9 back", 32'h60, 32'h0);
    apply("R9 swret", 0, 0, 1, 7'd100, 7'd50, 1, 32'h70, 32'h0, 0, 0, 32'h700, 32'h704);
    // R6: software trap with traps disabled
    apply("R6 fault", 0, 0, 1, 7'd3, 7'd4, 0, 0, 0, 0, 0, 32'h800, 32'h804);
    // R11: everything ignored while in error mode
    hw("R11 hw", 8'h22, 32'h900);
    apply("R11 sw", 0, 0, 1, 7'd9, 7'd9, 0, 0, 0, 0, 0, 0, 0);
    ret("R11 ret", 32'h123, 32'h0);
    apply("R11 wr", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h12345, 0, 0);
    idle("R11 idle");
    do_reset();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule